// File: doc/BRIEF.md
# Vectored Four-Source Interrupt Controller

This block sits beside the core of a small 8-bit microcontroller and turns four request sources into vectored calls. The sources are a falling edge on an external pin, a periodic time-base tick, a real-time-clock tick and a timer overflow; the last three arrive as one-cycle pulses. Each source has a latched request flag and an enable bit. A global master enable gates them all. Software sees all of these bits through two byte-wide control/status registers.

The core supplies a sample strobe that marks its evaluation points. It also supplies a stack-full indication and one-cycle pulses for the two return forms. At a sample point the controller may accept the highest-priority request that is pending and enabled. It can do so only when the master enable is set and the stack has room. On acceptance it clears that source's flag and the master enable, then holds a call request with the source's fixed vector until the core acknowledges it. Flags keep latching while the master enable is off, so no event is dropped. Only the interrupt-return form turns the master enable back on.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset both register read ports are 0x00 and `call_req` is low.
- R2: Writing register 0 (`reg_sel`=0) sets bit0 master enable, bit1 external enable, bit2 time-base enable, bit3 RTC enable, bit4 external flag, bit5 time-base flag and bit6 RTC flag. Bit7 always reads 0. Register 1 (`reg_sel`=1) holds bit0 timer enable and bit4 timer flag; its other bits read 0.
- R3: A high-to-low transition on `ext_pin` sets the external flag (register 0 bit4). A low-to-high transition does not.
- R4: A pulse on `tb_tick`, `rtc_tick` or `tmr_ovf` sets its flag (reg0 bit5, reg0 bit6, reg1 bit4). This happens even while the master enable is 0.
- R5: Accepted requests present `call_vec` 0x04 for external, 0x08 for time base, 0x0C for RTC and 0x10 for timer.
- R6: When several requests are pending and enabled together, the lowest vector wins: external, then time base, then RTC, then timer. The losers stay pending.
- R7: Acceptance clears the winning source's flag and the master enable in the same cycle that `call_req` rises. Other flags are unchanged.
- R8: No request is accepted while `stack_full` is high. The flag stays set and is accepted once `stack_full` falls.
- R9: A `reti_pulse` sets the master enable. A `ret_pulse` leaves it unchanged.
- R10: Acceptance happens only in a cycle where `sample` is high. Requests that arrive between sample points are arbitrated together at the next one.
- R11: A hardware set event in the same cycle as a software write of 0 to that flag leaves the flag set.
- R12: `call_req` and `call_vec` stay stable until `call_ack` is high; `call_req` falls on the following edge.
- R13: A pending flag whose enable bit is 0 is never accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_pin | input | 1 | External interrupt pin, idle high |
| tb_tick | input | 1 | Time-base tick pulse |
| rtc_tick | input | 1 | Real-time-clock tick pulse |
| tmr_ovf | input | 1 | Timer overflow pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select, 0 or 1 |
| reg_wdata | input | 8 | Register write data |
| reg0_rdata | output | 8 | Register 0 contents |
| reg1_rdata | output | 8 | Register 1 contents |
| stack_full | input | 1 | Return-address stack is full |
| sample | input | 1 | Core evaluation point strobe |
| ret_pulse | input | 1 | Plain return executed |
| reti_pulse | input | 1 | Interrupt return executed |
| call_req | output | 1 | Vectored call request |
| call_vec | output | 8 | Vector address of the call |
| call_ack | input | 1 | Core takes the call |

## Verification
The hardest case to create is two sources arriving at different times and being arbitrated in one decision. Acceptance happens at the first sample point after a flag sets, so a later, higher-priority request would normally lose. The bench holds `sample` low and fires the RTC tick before the time-base tick. It then raises a single sample strobe and expects the time-base vector, with the RTC flag still pending. The same-cycle collision of a software clear with a hardware tick is also forced, by aligning the write strobe and the tick on one edge.

// File: rtl/irq_vc_pkg.sv
package irq_vc_pkg;
   localparam int NUM_SRC = 4;
   typedef enum logic [1:0] {
      SRC_EXT = 2'd0,
      SRC_TB  = 2'd1,
      SRC_RTC = 2'd2,
      SRC_TMR = 2'd3
   } irq_src_e;

   function automatic logic [15:0] vec_of(input int idx, input int base, input int stride);
      vec_of = 16'(base + idx * stride);
   endfunction
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic fall
);
   logic [SYNC_STAGES:0] chain;
   logic                 prev_q;

   assign chain[0] = pin;

   generate
      for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
         always_ff @(posedge clk) begin
            if (!rst_n) chain[s+1] <= 1'b1;
            else        chain[s+1] <= chain[s];
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= chain[SYNC_STAGES];
   end

   assign fall = prev_q & ~chain[SYNC_STAGES];
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] hw_set,
   input  logic [N-1:0] sw_wr,
   input  logic [N-1:0] sw_val,
   input  logic [N-1:0] acc_clr,
   output logic [N-1:0] flag
);
   generate
      for (genvar i = 0; i < N; i++) begin : g_flag
         logic nxt;
         always_comb begin
            nxt = flag[i];
            if (sw_wr[i])   nxt = sw_val[i];
            if (acc_clr[i]) nxt = 1'b0;
            if (hw_set[i])  nxt = 1'b1;
         end
         always_ff @(posedge clk) begin
            if (!rst_n) flag[i] <= 1'b0;
            else        flag[i] <= nxt;
         end
      end
   endgenerate
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel #(
   parameter int N = 4,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic          any,
   output logic [IW-1:0] idx,
   output logic [N-1:0]  grant
);
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IW'(i);
      end
   end

   assign any = |req;

   generate
      for (genvar g = 0; g < N; g++) begin : g_grant
         assign grant[g] = any && (idx == IW'(g));
      end
   endgenerate
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
   import irq_vc_pkg::*;
#(
   parameter int VEC_W       = 8,
   parameter int VEC_BASE    = 4,
   parameter int VEC_STRIDE  = 4,
   parameter int SYNC_STAGES = 2,
   parameter bit SAMPLE_GATED = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ext_pin,
   input  logic             tb_tick,
   input  logic             rtc_tick,
   input  logic             tmr_ovf,
   input  logic             reg_wr,
   input  logic             reg_sel,
   input  logic [7:0]       reg_wdata,
   output logic [7:0]       reg0_rdata,
   output logic [7:0]       reg1_rdata,
   input  logic             stack_full,
   input  logic             sample,
   input  logic             ret_pulse,
   input  logic             reti_pulse,
   output logic             call_req,
   output logic [VEC_W-1:0] call_vec,
   input  logic             call_ack
);
   localparam int IW      = $clog2(NUM_SRC);
   localparam int VEC_TOP = VEC_BASE + (NUM_SRC - 1) * VEC_STRIDE;

   initial begin
      if (VEC_W < 1 || VEC_W > 16)
         $error("VEC_W must be 1..16");
      if (VEC_TOP >= (1 << VEC_W))
         $error("vector range does not fit VEC_W");
      if (VEC_STRIDE < 1)
         $error("VEC_STRIDE must be positive");
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4)
         $error("SYNC_STAGES must be 0..4");
   end

   logic                 emi_q;
   logic [NUM_SRC-1:0]   en_q;
   logic [NUM_SRC-1:0]   flag;
   logic [NUM_SRC-1:0]   hw_set;
   logic [NUM_SRC-1:0]   sw_wr;
   logic [NUM_SRC-1:0]   sw_val;
   logic [NUM_SRC-1:0]   acc_clr;
   logic [NUM_SRC-1:0]   grant;
   logic                 any_req;
   logic [IW-1:0]        win_idx;
   logic                 ext_fall;
   logic                 eval_pt;
   logic                 accept;
   logic                 wr0;
   logic                 wr1;

   irq_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .pin   (ext_pin),
      .fall  (ext_fall)
   );

   assign wr0 = reg_wr & ~reg_sel;
   assign wr1 = reg_wr &  reg_sel;

   assign hw_set[SRC_EXT] = ext_fall;
   assign hw_set[SRC_TB]  = tb_tick;
   assign hw_set[SRC_RTC] = rtc_tick;
   assign hw_set[SRC_TMR] = tmr_ovf;

   assign sw_wr  = {wr1, wr0, wr0, wr0};
   assign sw_val = {reg_wdata[4], reg_wdata[6], reg_wdata[5], reg_wdata[4]};

   irq_flag_bank #(.N(NUM_SRC)) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .hw_set  (hw_set),
      .sw_wr   (sw_wr),
      .sw_val  (sw_val),
      .acc_clr (acc_clr),
      .flag    (flag)
   );

   irq_prio_sel #(.N(NUM_SRC)) u_prio (
      .req   (flag & en_q),
      .any   (any_req),
      .idx   (win_idx),
      .grant (grant)
   );

   generate
      if (SAMPLE_GATED) begin : g_gated
         assign eval_pt = sample;
      end else begin : g_free
         assign eval_pt = 1'b1;
      end
   endgenerate

   assign accept  = eval_pt & emi_q & ~stack_full & ~call_req & any_req;
   assign acc_clr = accept ? grant : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q <= '0;
      end else begin
         if (wr0) en_q[SRC_RTC:SRC_EXT] <= reg_wdata[3:1];
         if (wr1) en_q[SRC_TMR]         <= reg_wdata[0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)          emi_q <= 1'b0;
      else if (accept)     emi_q <= 1'b0;
      else if (reti_pulse) emi_q <= 1'b1;
      else if (wr0)        emi_q <= reg_wdata[0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         call_req <= 1'b0;
         call_vec <= '0;
      end else if (accept) begin
         call_req <= 1'b1;
         call_vec <= VEC_W'(vec_of(int'(win_idx), VEC_BASE, VEC_STRIDE));
      end else if (call_req && call_ack) begin
         call_req <= 1'b0;
      end
   end

   assign reg0_rdata = {1'b0, flag[SRC_RTC], flag[SRC_TB], flag[SRC_EXT],
                        en_q[SRC_RTC], en_q[SRC_TB], en_q[SRC_EXT], emi_q};
   assign reg1_rdata = {3'b000, flag[SRC_TMR], 3'b000, en_q[SRC_TMR]};
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk #(
   parameter int VEC_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_wr,
   input logic             reg_sel,
   input logic [7:0]       reg0_rdata,
   input logic [7:0]       reg1_rdata,
   input logic             stack_full,
   input logic             sample,
   input logic             reti_pulse,
   input logic             call_req,
   input logic [VEC_W-1:0] call_vec,
   input logic             call_ack
);
   AST_ACCEPT_DROPS_EMI: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(call_req) |-> !reg0_rdata[0]); // R7

   AST_NO_ACCEPT_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(call_req) |-> !$past(stack_full)); // R8

   AST_ACCEPT_AT_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(call_req) |-> $past(sample)); // R10

   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (call_req && !call_ack) |=> (call_req && $stable(call_vec))); // R12

   AST_VEC_IN_SET: assert property (@(posedge clk) disable iff (!rst_n)
      call_req |-> (call_vec == 'h04 || call_vec == 'h08 ||
                    call_vec == 'h0C || call_vec == 'h10)); // R5

   AST_RETI_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
      (reti_pulse && !(reg_wr && !reg_sel)) |=> (reg0_rdata[0] || $rose(call_req))); // R9

   AST_UNUSED_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg0_rdata[7] && ((reg1_rdata & 8'hEE) == 8'h00))); // R2
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(.VEC_W(VEC_W)) u_chk (.*);

// File: tb/irq_vector_ctrl_bench.sv
module irq_vector_ctrl_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ext_pin = 1'b1;
   logic       tb_tick = 1'b0, rtc_tick = 1'b0, tmr_ovf = 1'b0;
   logic       reg_wr = 1'b0, reg_sel = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg0_rdata, reg1_rdata;
   logic       stack_full = 1'b0, sample = 1'b1;
   logic       ret_pulse = 1'b0, reti_pulse = 1'b0;
   logic       call_req;
   logic [7:0] call_vec;
   logic       call_ack = 1'b0;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   irq_vector_ctrl u_irq_vector_ctrl (
      .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .tb_tick(tb_tick),
      .rtc_tick(rtc_tick), .tmr_ovf(tmr_ovf), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg0_rdata(reg0_rdata), .reg1_rdata(reg1_rdata),
      .stack_full(stack_full), .sample(sample), .ret_pulse(ret_pulse),
      .reti_pulse(reti_pulse), .call_req(call_req), .call_vec(call_vec),
      .call_ack(call_ack)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr_reg(input logic sel, input logic [7:0] d);
      reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic pulse_tb();  tb_tick = 1'b1;  @(negedge clk); tb_tick = 1'b0;  endtask
   task automatic pulse_rtc(); rtc_tick = 1'b1; @(negedge clk); rtc_tick = 1'b0; endtask
   task automatic pulse_tmr(); tmr_ovf = 1'b1;  @(negedge clk); tmr_ovf = 1'b0;  endtask

   task automatic ack();
      call_ack = 1'b1; @(negedge clk); call_ack = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 reg0", 16'(reg0_rdata), 16'h00);
      chk("R1 reg1", 16'(reg1_rdata), 16'h00);
      chk("R1 call_req", 16'(call_req), 16'h0);
   endtask

   task automatic t_layout();
      wr_reg(1'b0, 8'hFE);
      chk("R2 reg0 readback", 16'(reg0_rdata), 16'h7E);
      wr_reg(1'b1, 8'hFF);
      chk("R2 reg1 readback", 16'(reg1_rdata), 16'h11);
      wr_reg(1'b0, 8'h00);
      wr_reg(1'b1, 8'h00);
      chk("R2 cleared", 16'({reg0_rdata, reg1_rdata}), 16'h0000);
   endtask

   task automatic t_edge();
      ext_pin = 1'b0; cyc(5);
      chk("R3 fall sets flag", 16'(reg0_rdata[4]), 16'h1);
      wr_reg(1'b0, 8'h00);
      ext_pin = 1'b1; cyc(5);
      chk("R3 rise ignored", 16'(reg0_rdata[4]), 16'h0);
   endtask

   task automatic t_latch_disabled();
      pulse_tb(); pulse_rtc(); pulse_tmr(); cyc(1);
      chk("R4 flags latch with EMI off", 16'(reg0_rdata), 16'h60);
      chk("R4 timer flag", 16'(reg1_rdata), 16'h10);
      chk("R4 no call", 16'(call_req), 16'h0);
      wr_reg(1'b0, 8'h00); wr_reg(1'b1, 8'h00);
   endtask

   task automatic t_priority();
      sample = 1'b0;
      wr_reg(1'b1, 8'h01);
      wr_reg(1'b0, 8'h0F);
      pulse_tmr(); pulse_rtc(); pulse_tb(); cyc(2);
      chk("R10 no accept without sample", 16'(call_req), 16'h0);
      sample = 1'b1; @(negedge clk); sample = 1'b0;
      chk("R6 R10 time base wins", 16'({call_req, call_vec}), 16'h0108);
      chk("R7 own flag and EMI cleared", 16'(reg0_rdata), 16'h4E);
      cyc(2);
      chk("R12 held until ack", 16'({call_req, call_vec}), 16'h0108);
      ack();
      chk("R12 drops after ack", 16'(call_req), 16'h0);
      sample = 1'b1;
      wr_reg(1'b0, 8'h4F); cyc(1);
      chk("R5 RTC vector", 16'({call_req, call_vec}), 16'h010C);
      ack();
      wr_reg(1'b0, 8'h0F); cyc(1);
      chk("R5 timer vector", 16'({call_req, call_vec}), 16'h0110);
      chk("R7 timer flag cleared", 16'(reg1_rdata), 16'h01);
      ack();
      ext_pin = 1'b0; cyc(1); wr_reg(1'b0, 8'h0F); cyc(4);
      chk("R5 external vector", 16'({call_req, call_vec}), 16'h0104);
      ack(); ext_pin = 1'b1; cyc(4);
      wr_reg(1'b0, 8'h00); wr_reg(1'b1, 8'h00);
   endtask

   task automatic t_stack_full();
      wr_reg(1'b1, 8'h01);
      stack_full = 1'b1;
      wr_reg(1'b0, 8'h01);
      pulse_tmr(); cyc(3);
      chk("R8 blocked when full", 16'(call_req), 16'h0);
      chk("R8 flag pending", 16'(reg1_rdata), 16'h11);
      stack_full = 1'b0; cyc(1);
      chk("R8 accepted after release", 16'({call_req, call_vec}), 16'h0110);
      ack();
      wr_reg(1'b1, 8'h00);
   endtask

   task automatic t_returns();
      wr_reg(1'b0, 8'h00);
      ret_pulse = 1'b1; @(negedge clk); ret_pulse = 1'b0;
      chk("R9 RET leaves EMI", 16'(reg0_rdata[0]), 16'h0);
      reti_pulse = 1'b1; @(negedge clk); reti_pulse = 1'b0;
      chk("R9 RETI sets EMI", 16'(reg0_rdata[0]), 16'h1);
      wr_reg(1'b0, 8'h00);
   endtask

   task automatic t_collision();
      pulse_tb();
      tb_tick = 1'b1;
      wr_reg(1'b0, 8'h00);
      tb_tick = 1'b0;
      chk("R11 hw set beats sw clear", 16'(reg0_rdata[5]), 16'h1);
      wr_reg(1'b0, 8'h00);
      chk("R11 plain sw clear works", 16'(reg0_rdata[5]), 16'h0);
   endtask

   task automatic t_mask();
      wr_reg(1'b0, 8'h0B);
      pulse_tb(); cyc(3);
      chk("R13 masked source ignored", 16'(call_req), 16'h0);
      chk("R13 flag still pending", 16'(reg0_rdata), 16'h2B);
      wr_reg(1'b0, 8'h00);
   endtask

   initial begin
      cyc(3);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_layout();
      t_edge();
      t_latch_disabled();
      t_priority();
      t_stack_full();
      t_returns();
      t_collision();
      t_mask();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule